// File: doc/BRIEF.md
# Double-Buffered Parameter Load Controller

This block keeps two copies of the parameters that a position counter needs: several compare values, an initial value and a modulus value. Software writes the staging (outer) copy through simple per-register write strobes. The counter only ever sees the working (inner) copy. A load-okay flag decides when the staged values move into the working copy.

In immediate mode, a request to load moves the whole staging set into the working set in the same cycle. In wrap mode, the request stays pending until the counter reports its next roll-over or roll-under. With the DMA handshake enabled, each completed transfer raises a DMA request and clears load-okay. When the DMA engine acknowledges, load-okay is armed again on its own, so refills can continue without software.

Top module: `qpl_dbuf_loader`

## Requirements
- R1: After reset every working register reads zero, and both load-okay and the DMA request are low.
- R2: While load-okay is low and no load request is applied, roll-over and roll-under strobes and staging writes leave the working registers unchanged.
- R3: With `ld_mode_i` = 0 (immediate), a `ldok_set_i` pulse copies every staging register into its working register. The working outputs show the new values one clock later, and load-okay reads low at that point.
- R4: With `ld_mode_i` = 1 (wrap), a `ldok_set_i` pulse makes load-okay read high from the next clock on, and the working registers stay unchanged. Load-okay stays high until a roll-over or roll-under strobe arrives. One clock after that strobe, the working registers hold the staging values and load-okay reads low.
- R5: In wrap mode, a `ldok_set_i` pulse that coincides with a roll-over or roll-under strobe transfers on that strobe. The result shows one clock later, and load-okay reads low.
- R6: With `dma_en_i` = 1, a transfer drives `dma_req_o` high one clock later, and load-okay reads low at that point.
- R7: `dma_req_o` stays high until `dma_done_i` is sampled high. It reads low one clock after that, and load-okay reads high in the same clock.
- R8: A staging write in the same cycle as a transfer does not reach the working register in that transfer. The working register takes the previously staged value, and the new value waits for the next transfer.
- R9: Register index k of `wr_en_i` addresses compare register k for k below NCMP. Index NCMP is the initial value, and index NCMP+1 is the modulus. Compare register k appears at bits [k*PW +: PW] of `inner_cmp_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | NCMP+2 | Per-register staging write strobes |
| wr_data_i | input | PW | Write data shared by all strobes |
| ldok_set_i | input | 1 | Software request to set load-okay |
| ld_mode_i | input | 1 | 0 = load immediately, 1 = load at next wrap |
| roll_over_i | input | 1 | Counter roll-over strobe |
| roll_under_i | input | 1 | Counter roll-under strobe |
| dma_en_i | input | 1 | Enables the DMA request handshake |
| dma_done_i | input | 1 | DMA completion acknowledgment |
| inner_cmp_o | output | NCMP*PW | Working compare values, packed |
| inner_init_o | output | PW | Working initial value |
| inner_mod_o | output | PW | Working modulus value |
| ldok_o | output | 1 | Live load-okay status |
| dma_req_o | output | 1 | DMA request |

## Verification
Every result here sits one register behind its cause. A transfer decided in cycle t shows on the working outputs, on load-okay and on the DMA request at the edge that ends cycle t. A staging write lands one edge earlier than any transfer that could use it. The bench drives stimulus just after a falling edge, holds it across exactly one rising edge, and then samples at the next falling edge. Each check therefore sees the state one clock after its stimulus and before any later stimulus applies. Waiting periods, such as a pending wrap-mode load or a pending DMA request, are checked by idling several single clocks and sampling after each one.

// File: rtl/qpl_pkg.sv
package qpl_pkg;

    typedef enum logic {
        LD_NOW     = 1'b0,
        LD_AT_WRAP = 1'b1
    } ld_mode_e;

    typedef struct packed {
        logic ldok;
        logic dma_req;
    } ctrl_state_t;

endpackage

// File: rtl/qpl_stage_bank.sv
module qpl_stage_bank #(
    parameter int PW   = 32,
    parameter int NREG = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NREG-1:0]     wr_en_i,
    input  logic [PW-1:0]       wr_data_i,
    output logic [NREG*PW-1:0]  stage_o
);
    logic [PW-1:0] stage_d [NREG];
    logic [PW-1:0] stage_q [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_comb begin
            stage_d[g] = stage_q[g];
            if (wr_en_i[g]) stage_d[g] = wr_data_i;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[g] <= '0;
            else        stage_q[g] <= stage_d[g];
        end

        assign stage_o[g*PW +: PW] = stage_q[g];
    end
endmodule

// File: rtl/qpl_work_bank.sv
module qpl_work_bank #(
    parameter int PW   = 32,
    parameter int NREG = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                xfer_i,
    input  logic [NREG*PW-1:0]  stage_i,
    output logic [NREG*PW-1:0]  work_o
);
    logic [NREG*PW-1:0] work_d;
    logic [NREG*PW-1:0] work_q;

    always_comb begin
        work_d = work_q;
        if (xfer_i) work_d = stage_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) work_q <= '0;
        else        work_q <= work_d;
    end

    assign work_o = work_q;
endmodule

// File: rtl/qpl_load_ctrl.sv
module qpl_load_ctrl
    import qpl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ldok_set_i,
    input  logic ld_mode_i,
    input  logic roll_over_i,
    input  logic roll_under_i,
    input  logic dma_en_i,
    input  logic dma_done_i,
    output logic xfer_o,
    output logic ldok_o,
    output logic dma_req_o
);
    ctrl_state_t st_d;
    ctrl_state_t st_q;
    logic        pend;
    logic        wrap;
    logic        xfer;

    always_comb begin
        st_d = st_q;
        pend = st_q.ldok | ldok_set_i;
        wrap = roll_over_i | roll_under_i;
        xfer = pend && ((ld_mode_e'(ld_mode_i) == LD_NOW) || wrap);

        st_d.ldok = xfer ? 1'b0 : pend;

        if (st_q.dma_req && dma_done_i) begin
            st_d.dma_req = 1'b0;
            st_d.ldok    = 1'b1;
        end
        if (xfer && dma_en_i) st_d.dma_req = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign xfer_o    = xfer;
    assign ldok_o    = st_q.ldok;
    assign dma_req_o = st_q.dma_req;
endmodule

// File: rtl/qpl_dbuf_loader.sv
module qpl_dbuf_loader #(
    parameter int PW   = 32,
    parameter int NCMP = 4,
    localparam int NREG = NCMP + 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NREG-1:0]     wr_en_i,
    input  logic [PW-1:0]       wr_data_i,
    input  logic                ldok_set_i,
    input  logic                ld_mode_i,
    input  logic                roll_over_i,
    input  logic                roll_under_i,
    input  logic                dma_en_i,
    input  logic                dma_done_i,
    output logic [NCMP*PW-1:0]  inner_cmp_o,
    output logic [PW-1:0]       inner_init_o,
    output logic [PW-1:0]       inner_mod_o,
    output logic                ldok_o,
    output logic                dma_req_o
);
    localparam int IDX_INIT = NCMP;
    localparam int IDX_MOD  = NCMP + 1;

    logic [NREG*PW-1:0] stage;
    logic [NREG*PW-1:0] work;
    logic               xfer;

    qpl_stage_bank #(.PW(PW), .NREG(NREG)) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .stage_o   (stage)
    );

    qpl_load_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .ldok_set_i   (ldok_set_i),
        .ld_mode_i    (ld_mode_i),
        .roll_over_i  (roll_over_i),
        .roll_under_i (roll_under_i),
        .dma_en_i     (dma_en_i),
        .dma_done_i   (dma_done_i),
        .xfer_o       (xfer),
        .ldok_o       (ldok_o),
        .dma_req_o    (dma_req_o)
    );

    qpl_work_bank #(.PW(PW), .NREG(NREG)) u_work (
        .clk     (clk),
        .rst_n   (rst_n),
        .xfer_i  (xfer),
        .stage_i (stage),
        .work_o  (work)
    );

    // R9: compare registers occupy the low indices, then initial, then modulus
    assign inner_cmp_o  = work[NCMP*PW-1:0];
    assign inner_init_o = work[IDX_INIT*PW +: PW];
    assign inner_mod_o  = work[IDX_MOD*PW +: PW];
endmodule

// File: rtl/qpl_dbuf_loader_chk.sv
module qpl_dbuf_loader_chk #(
    parameter int PW   = 32,
    parameter int NCMP = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                ldok_set_i,
    input logic                ld_mode_i,
    input logic                roll_over_i,
    input logic                roll_under_i,
    input logic                dma_en_i,
    input logic                dma_done_i,
    input logic [NCMP*PW-1:0]  inner_cmp_o,
    input logic [PW-1:0]       inner_init_o,
    input logic [PW-1:0]       inner_mod_o,
    input logic                ldok_o,
    input logic                dma_req_o
);
    logic [(NCMP+2)*PW-1:0] work_all;
    logic                   may_load;

    assign work_all = {inner_cmp_o, inner_init_o, inner_mod_o};
    assign may_load = (ldok_o || ldok_set_i) && (!ld_mode_i || roll_over_i || roll_under_i);

    AST_WORK_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(work_all) |-> $past(may_load)); // R2

    AST_NOW_MODE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_mode_i && !(dma_req_o && dma_done_i)) |=> !ldok_o); // R3

    AST_WRAP_MODE_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_mode_i && ldok_o && !roll_over_i && !roll_under_i) |=> ldok_o); // R4

    AST_DMA_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_en_i && may_load) |=> dma_req_o); // R6

    AST_DMA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req_o && !dma_done_i) |=> dma_req_o); // R7

    AST_DMA_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req_o && dma_done_i) |=> ldok_o); // R7

    AST_DMA_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req_o && dma_done_i && !(dma_en_i && may_load)) |=> !dma_req_o); // R7
endmodule

bind qpl_dbuf_loader qpl_dbuf_loader_chk #(.PW(PW), .NCMP(NCMP)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ldok_set_i   (ldok_set_i),
    .ld_mode_i    (ld_mode_i),
    .roll_over_i  (roll_over_i),
    .roll_under_i (roll_under_i),
    .dma_en_i     (dma_en_i),
    .dma_done_i   (dma_done_i),
    .inner_cmp_o  (inner_cmp_o),
    .inner_init_o (inner_init_o),
    .inner_mod_o  (inner_mod_o),
    .ldok_o       (ldok_o),
    .dma_req_o    (dma_req_o)
);

// File: tb/sim_qpl_dbuf_loader.sv
module sim_qpl_dbuf_loader;
    localparam int PW       = 32;
    localparam int NCMP     = 4;
    localparam int NREG     = NCMP + 2;
    localparam int CLK_PER  = 10;
    localparam int NVEC     = 8;

    // {mode, set, roll_over, roll_under, exp_ldok, exp_loaded}
    localparam logic [5:0] VEC [NVEC] = '{
        6'b0_0_1_0_0_0,  // R2: no request, roll ignored
        6'b0_1_0_0_0_1,  // R3: immediate load
        6'b1_1_0_0_1_0,  // R4: wrap mode, pending
        6'b1_0_0_0_1_0,  // R4: still pending
        6'b1_0_0_1_0_1,  // R4: roll-under loads
        6'b1_1_1_0_0_1,  // R5: set with roll-over
        6'b1_0_1_0_0_0,  // R2: roll with nothing pending
        6'b1_1_0_1_0_1   // R5: set with roll-under
    };

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [NREG-1:0]     wr_en = '0;
    logic [PW-1:0]       wr_data = '0;
    logic                ldok_set = 1'b0;
    logic                ld_mode = 1'b0;
    logic                roll_over = 1'b0;
    logic                roll_under = 1'b0;
    logic                dma_en = 1'b0;
    logic                dma_done = 1'b0;
    logic [NCMP*PW-1:0]  inner_cmp;
    logic [PW-1:0]       inner_init;
    logic [PW-1:0]       inner_mod;
    logic                ldok;
    logic                dma_req;

    int n_chk = 0;
    int n_fail = 0;
    logic [PW-1:0] exp_cmp0;

    always #(CLK_PER/2) clk = ~clk;

    qpl_dbuf_loader #(.PW(PW), .NCMP(NCMP)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
        .ldok_set_i(ldok_set), .ld_mode_i(ld_mode), .roll_over_i(roll_over),
        .roll_under_i(roll_under), .dma_en_i(dma_en), .dma_done_i(dma_done),
        .inner_cmp_o(inner_cmp), .inner_init_o(inner_init), .inner_mod_o(inner_mod),
        .ldok_o(ldok), .dma_req_o(dma_req)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input logic [PW-1:0] act,
                         input logic [PW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic quiet();
        wr_en = '0; ldok_set = 1'b0; roll_over = 1'b0; roll_under = 1'b0; dma_done = 1'b0;
    endtask

    function automatic logic [PW-1:0] cmp(input int k);
        return inner_cmp[k*PW +: PW];
    endfunction

    initial begin
        #(CLK_PER * 100000);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(inner_cmp == '0, "R1", cmp(0), '0);
        check(inner_init == '0, "R1", inner_init, '0);
        check(inner_mod == '0, "R1", inner_mod, '0);
        check(ldok == 1'b0, "R1", PW'(ldok), '0);
        check(dma_req == 1'b0, "R1", PW'(dma_req), '0);
        rst_n = 1'b1;
        step();

        exp_cmp0 = '0;
        for (int k = 0; k < NVEC; k++) begin
            logic [PW-1:0] val;
            val = PW'(32'h1000 + k);
            wr_en = NREG'(1); wr_data = val; ld_mode = VEC[k][5];
            step();
            quiet();
            ldok_set = VEC[k][4]; roll_over = VEC[k][3]; roll_under = VEC[k][2];
            step();
            quiet();
            if (VEC[k][0]) exp_cmp0 = val;
            check(ldok == VEC[k][1], $sformatf("R2-R5 vec%0d ldok", k), PW'(ldok), PW'(VEC[k][1]));
            check(cmp(0) == exp_cmp0, $sformatf("R2-R5 vec%0d cmp0", k), cmp(0), exp_cmp0);
        end

        // R9 and R3: every register moves in one immediate load
        ld_mode = 1'b0;
        wr_en = NREG'(1) << 3;        wr_data = 32'hC3C3_0003; step();
        wr_en = NREG'(1) << NCMP;     wr_data = 32'h1A17_0000; step();
        wr_en = NREG'(1) << (NCMP+1); wr_data = 32'h0000_0FFF; step();
        quiet(); ldok_set = 1'b1; step(); quiet();
        check(cmp(3) == 32'hC3C3_0003, "R9 cmp3", cmp(3), 32'hC3C3_0003);
        check(inner_init == 32'h1A17_0000, "R9 init", inner_init, 32'h1A17_0000);
        check(inner_mod == 32'h0000_0FFF, "R9 mod", inner_mod, 32'h0000_0FFF);
        check(ldok == 1'b0, "R3 ldok", PW'(ldok), '0);

        // R8: a write in the transfer cycle misses that transfer
        wr_en = NREG'(1) << 1; wr_data = 32'hAAAA_0001; step();
        wr_data = 32'hBBBB_0002; ldok_set = 1'b1; step(); quiet();
        check(cmp(1) == 32'hAAAA_0001, "R8 old value", cmp(1), 32'hAAAA_0001);
        ldok_set = 1'b1; step(); quiet();
        check(cmp(1) == 32'hBBBB_0002, "R8 next load", cmp(1), 32'hBBBB_0002);

        // R6 / R7: DMA handshake
        dma_en = 1'b1;
        wr_en = NREG'(1) << 2; wr_data = 32'h0D0A_0001; step(); quiet();
        ldok_set = 1'b1; step(); quiet();
        check(dma_req == 1'b1, "R6 req", PW'(dma_req), 1);
        check(ldok == 1'b0, "R6 ldok", PW'(ldok), 0);
        check(cmp(2) == 32'h0D0A_0001, "R6 load", cmp(2), 32'h0D0A_0001);
        for (int i = 0; i < 3; i++) begin
            step();
            check(dma_req == 1'b1, "R7 hold", PW'(dma_req), 1);
        end
        wr_en = NREG'(1) << 2; wr_data = 32'h0D0A_0002; step(); quiet();
        ld_mode = 1'b1;
        dma_done = 1'b1; step(); quiet();
        check(dma_req == 1'b0, "R7 drop", PW'(dma_req), 0);
        check(ldok == 1'b1, "R7 rearm", PW'(ldok), 1);
        check(cmp(2) == 32'h0D0A_0001, "R4 wait after rearm", cmp(2), 32'h0D0A_0001);
        roll_over = 1'b1; step(); quiet();
        check(cmp(2) == 32'h0D0A_0002, "R7 chained load", cmp(2), 32'h0D0A_0002);
        check(dma_req == 1'b1, "R6 second req", PW'(dma_req), 1);
        dma_en = 1'b0;
        step();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule